// File: doc/BRIEF.md
# I2C Controller Status Flag and Interrupt Unit

This unit sits beside the byte engine of an I2C bus controller and keeps the controller's status flags: five transfer-event flags (start condition sent, address phase done, byte stall, transmit holding empty, receive holding full), three fault flags (missing acknowledge, arbitration lost, bus fault) and a bus-busy flag. The byte engine reports each condition as a one-cycle pulse. Software sees the flags through two status registers. It clears them as a side effect of its normal register traffic: data-register accesses, a status read sequence, or write-zero-to-clear.

Three enable bits in a control register gate the flags onto two level interrupt lines, one for transfer events and one for faults. The buffer enable adds the holding-register flags to the event line and does not act alone. No data stream passes through this unit, so it has no valid/ready interface. The register port is a plain single-cycle strobe interface with combinational read data. Reads of the data register return zero here, because the byte engine supplies the received byte. A set pulse in the same cycle as a clearing access always wins.

Register select codes: 0 = control, 1 = data, 2 = status A, 3 = status B.

Top module: `i2c_stat_irq`

## Requirements
- R1: After reset every flag, every enable bit and both interrupt lines are 0, and all three readable registers return 0.
- R2: Each event pulse sets its flag, and the flag stays set until its clearing rule fires. Status A (select 2) shows start-sent at bit 0, address-done at bit 1, byte-stall at bit 2, receive-full at bit 6, transmit-empty at bit 7, bus fault at bit 8, arbitration lost at bit 9 and missing acknowledge at bit 10. All other bits read 0.
- R3: A write to the data register (select 1) clears start-sent and transmit-empty.
- R4: A read of the data register clears receive-full. Any data-register access, read or write, clears byte-stall.
- R5: Address-done clears only when a read of status A made while it was set is followed by a read of status B (select 3). A status B read with no such earlier status A read leaves it set.
- R6: A write to status A clears each fault flag whose bit is written 0 and keeps each one written 1. Such a write never changes event flags or busy.
- R7: A set pulse in the same cycle as a clearing action leaves the flag set.
- R8: The event line is high exactly when the event enable (control bit 9) is 1 and at least one of start-sent, address-done and byte-stall is set, or when the buffer condition of R9 holds.
- R9: With the event enable and the buffer enable (control bit 10) both 1, transmit-empty or receive-full also drive the event line. The buffer enable has no effect when the event enable is 0.
- R10: The fault line is high exactly when the fault enable (control bit 8) is 1 and any fault flag is set.
- R11: Status B bit 1 reports busy. Busy sets on a detected start and clears on a detected stop; a start in the same cycle as a stop leaves it set.
- R12: The control register reads back its three enable bits at bits 8, 9 and 10, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_start_sent | input | 1 | Pulse: start condition driven |
| evt_addr_sent | input | 1 | Pulse: address phase acknowledged |
| evt_byte_stall | input | 1 | Pulse: byte boundary reached with holding register not serviced |
| evt_tx_empty | input | 1 | Pulse: transmit holding register emptied |
| evt_rx_full | input | 1 | Pulse: receive holding register loaded |
| err_nack | input | 1 | Pulse: acknowledge missing |
| err_arb_lost | input | 1 | Pulse: arbitration lost |
| err_bus_fault | input | 1 | Pulse: misplaced start or stop |
| bus_start_det | input | 1 | Pulse: start seen on the bus |
| bus_stop_det | input | 1 | Pulse: stop seen on the bus |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq_event | output | 1 | Transfer-event interrupt line |
| irq_error | output | 1 | Fault interrupt line |

## Verification
The hardest state to reach is the two-step address-done clear. The clear needs a status A read that lands while the flag is set, then a status B read, with other accesses and new address pulses possibly in between. Directed sequences cover the status B read alone, the full pair, and the pair interleaved with a data access. Long random traffic then mixes all four selects with sparse pulses, so arm-then-clear chains and same-cycle set/clear collisions arise many times.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int REG_W = 16;
  localparam int SEL_W = 2;

  // flag storage indices
  localparam int F_SB   = 0;
  localparam int F_ADDR = 1;
  localparam int F_BTF  = 2;
  localparam int F_TXE  = 3;
  localparam int F_RXNE = 4;
  localparam int F_BERR = 5;
  localparam int F_ARLO = 6;
  localparam int F_AF   = 7;
  localparam int F_BUSY = 8;
  localparam int NFLAG  = 9;

  // software-visible bit positions
  localparam int B_SB = 0, B_ADDR = 1, B_BTF = 2, B_RXNE = 6, B_TXE = 7;
  localparam int B_BERR = 8, B_ARLO = 9, B_AF = 10;
  localparam int B_BUSY = 1;
  localparam int B_EN_ERR = 8, B_EN_EVT = 9, B_EN_BUF = 10;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STA  = 2'd2,
    SEL_STB  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_p,
  input  logic clr_p,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_p) q <= 1'b1;
    else if (clr_p) q <= 1'b0;
  end
endmodule

// File: rtl/i2c_addr_clr_seq.sv
module i2c_addr_clr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_flag,
  input  logic sta_rd,
  input  logic stb_rd,
  output logic addr_clr
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  armed_q <= 1'b0;
    else if (stb_rd)             armed_q <= 1'b0;
    else if (sta_rd && addr_flag) armed_q <= 1'b1;
  end

  assign addr_clr = stb_rd && armed_q;
endmodule

// File: rtl/i2c_irq_combine.sv
module i2c_irq_combine
  import i2c_stat_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic             en_evt,
  input  logic             en_buf,
  input  logic             en_err,
  output logic             irq_event,
  output logic             irq_error
);
  logic core_evt, buf_evt, any_err;

  always_comb begin
    core_evt  = flags[F_SB] | flags[F_ADDR] | flags[F_BTF];
    buf_evt   = en_buf & (flags[F_TXE] | flags[F_RXNE]);
    any_err   = flags[F_BERR] | flags[F_ARLO] | flags[F_AF];
    irq_event = en_evt & (core_evt | buf_evt);
    irq_error = en_err & any_err;
  end
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_start_sent,
  input  logic             evt_addr_sent,
  input  logic             evt_byte_stall,
  input  logic             evt_tx_empty,
  input  logic             evt_rx_full,
  input  logic             err_nack,
  input  logic             err_arb_lost,
  input  logic             err_bus_fault,
  input  logic             bus_start_det,
  input  logic             bus_stop_det,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_event,
  output logic             irq_error
);
  logic [NFLAG-1:0] flg_q, set_v, clr_v;
  logic en_evt_q, en_buf_q, en_err_q;
  logic data_wr, data_rd, sta_wr, sta_rd, stb_rd, ctrl_wr, addr_clr;

  assign data_wr = reg_wr && (reg_sel == SEL_DATA);
  assign data_rd = reg_rd && (reg_sel == SEL_DATA);
  assign sta_wr  = reg_wr && (reg_sel == SEL_STA);
  assign sta_rd  = reg_rd && (reg_sel == SEL_STA);
  assign stb_rd  = reg_rd && (reg_sel == SEL_STB);
  assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_evt_q <= 1'b0;
      en_buf_q <= 1'b0;
      en_err_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_evt_q <= reg_wdata[B_EN_EVT];
      en_buf_q <= reg_wdata[B_EN_BUF];
      en_err_q <= reg_wdata[B_EN_ERR];
    end
  end

  i2c_addr_clr_seq u_addr_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_flag(flg_q[F_ADDR]),
    .sta_rd   (sta_rd),
    .stb_rd   (stb_rd),
    .addr_clr (addr_clr)
  );

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[F_SB]   = evt_start_sent;
    set_v[F_ADDR] = evt_addr_sent;
    set_v[F_BTF]  = evt_byte_stall;
    set_v[F_TXE]  = evt_tx_empty;
    set_v[F_RXNE] = evt_rx_full;
    set_v[F_BERR] = err_bus_fault;
    set_v[F_ARLO] = err_arb_lost;
    set_v[F_AF]   = err_nack;
    set_v[F_BUSY] = bus_start_det;
    clr_v[F_SB]   = data_wr;
    clr_v[F_ADDR] = addr_clr;
    clr_v[F_BTF]  = data_wr | data_rd;
    clr_v[F_TXE]  = data_wr;
    clr_v[F_RXNE] = data_rd;
    clr_v[F_BERR] = sta_wr & ~reg_wdata[B_BERR];
    clr_v[F_ARLO] = sta_wr & ~reg_wdata[B_ARLO];
    clr_v[F_AF]   = sta_wr & ~reg_wdata[B_AF];
    clr_v[F_BUSY] = bus_stop_det;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    i2c_flag_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .set_p(set_v[i]),
      .clr_p(clr_v[i]),
      .q    (flg_q[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[B_EN_EVT] = en_evt_q;
        reg_rdata[B_EN_BUF] = en_buf_q;
        reg_rdata[B_EN_ERR] = en_err_q;
      end
      SEL_STA: begin
        reg_rdata[B_SB]   = flg_q[F_SB];
        reg_rdata[B_ADDR] = flg_q[F_ADDR];
        reg_rdata[B_BTF]  = flg_q[F_BTF];
        reg_rdata[B_RXNE] = flg_q[F_RXNE];
        reg_rdata[B_TXE]  = flg_q[F_TXE];
        reg_rdata[B_BERR] = flg_q[F_BERR];
        reg_rdata[B_ARLO] = flg_q[F_ARLO];
        reg_rdata[B_AF]   = flg_q[F_AF];
      end
      SEL_STB:  reg_rdata[B_BUSY] = flg_q[F_BUSY];
      default:  reg_rdata = '0;
    endcase
  end

  i2c_irq_combine u_irq (
    .flags    (flg_q),
    .en_evt   (en_evt_q),
    .en_buf   (en_buf_q),
    .en_err   (en_err_q),
    .irq_event(irq_event),
    .irq_error(irq_error)
  );
endmodule

// File: rtl/i2c_stat_irq_chk.sv
module i2c_stat_irq_chk
  import i2c_stat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             evt_start_sent,
  input logic             evt_addr_sent,
  input logic             err_nack,
  input logic             bus_start_det,
  input logic             bus_stop_det,
  input logic [SEL_W-1:0] reg_sel,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [REG_W-1:0] reg_wdata,
  input logic [NFLAG-1:0] flg_q,
  input logic             en_evt_q,
  input logic             en_err_q,
  input logic             irq_event,
  input logic             irq_error
);
  // R2
  start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start_sent |=> flg_q[F_SB]);

  // R3
  sb_data_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_DATA && !evt_start_sent) |=> !flg_q[F_SB]);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[F_ADDR] && !(reg_rd && reg_sel == SEL_STB)) |=> flg_q[F_ADDR]);

  // R6
  af_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[F_AF] && !(reg_wr && reg_sel == SEL_STA && !reg_wdata[B_AF])) |=> flg_q[F_AF]);

  // R8
  evt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_evt_q |-> !irq_event);

  // R10
  err_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_nack && en_err_q && !(reg_wr && reg_sel == SEL_CTRL)) |=> irq_error);

  // R11
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop_det && !bus_start_det) |=> !flg_q[F_BUSY]);

  // R11
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start_det |=> flg_q[F_BUSY]);
endmodule

bind i2c_stat_irq i2c_stat_irq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt_start_sent(evt_start_sent),
  .evt_addr_sent (evt_addr_sent),
  .err_nack      (err_nack),
  .bus_start_det (bus_start_det),
  .bus_stop_det  (bus_stop_det),
  .reg_sel       (reg_sel),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_wdata     (reg_wdata),
  .flg_q         (flg_q),
  .en_evt_q      (en_evt_q),
  .en_err_q      (en_err_q),
  .irq_event     (irq_event),
  .irq_error     (irq_error)
);

// File: tb/tb_i2c_stat_irq.sv
module tb_i2c_stat_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p_sb, p_addr, p_btf, p_txe, p_rxne, p_nack, p_arlo, p_berr, p_bst, p_bsp;
  logic [1:0]  sel;
  logic        wr, rd;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq_e, irq_x;

  int checks = 0;
  int fails = 0;
  string tag = "";

  // bench model state
  bit m_sb, m_addr, m_btf, m_txe, m_rxne, m_berr, m_arlo, m_af, m_busy;
  bit m_arm, m_een, m_ben, m_xen;

  always #5 clk = ~clk;

  i2c_stat_irq dut (
    .clk(clk), .rst_n(rst_n),
    .evt_start_sent(p_sb), .evt_addr_sent(p_addr), .evt_byte_stall(p_btf),
    .evt_tx_empty(p_txe), .evt_rx_full(p_rxne),
    .err_nack(p_nack), .err_arb_lost(p_arlo), .err_bus_fault(p_berr),
    .bus_start_det(p_bst), .bus_stop_det(p_bsp),
    .reg_sel(sel), .reg_wr(wr), .reg_rd(rd), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_event(irq_e), .irq_error(irq_x)
  );

  function automatic logic [15:0] exp_read(input logic [1:0] s);
    logic [15:0] v = '0;
    case (s)
      2'd0: begin v[8] = m_xen; v[9] = m_een; v[10] = m_ben; end
      2'd2: begin
        v[0] = m_sb; v[1] = m_addr; v[2] = m_btf; v[6] = m_rxne; v[7] = m_txe;
        v[8] = m_berr; v[9] = m_arlo; v[10] = m_af;
      end
      2'd3: v[1] = m_busy;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic bit exp_evt();
    return m_een && (m_sb || m_addr || m_btf || (m_ben && (m_txe || m_rxne)));
  endfunction

  function automatic bit exp_err();
    return m_xen && (m_af || m_arlo || m_berr);
  endfunction

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic idle();
    {p_sb, p_addr, p_btf, p_txe, p_rxne, p_nack, p_arlo, p_berr, p_bst, p_bsp} = '0;
    wr = 1'b0; rd = 1'b0; sel = 2'd0; wdata = '0;
  endtask

  // evaluate outputs against model, then advance model and clock
  task automatic cycle();
    bit dwr, drd, awr, ard, brd;
    #1;
    chk({tag, " R8/R9 event line"}, {15'd0, irq_e}, {15'd0, exp_evt()});
    chk({tag, " R10 fault line"}, {15'd0, irq_x}, {15'd0, exp_err()});
    if (rd) chk({tag, " R2/R11/R12 read data"}, rdata, exp_read(sel));
    dwr = wr && sel == 2'd1; drd = rd && sel == 2'd1;
    awr = wr && sel == 2'd2; ard = rd && sel == 2'd2; brd = rd && sel == 2'd3;
    if (wr && sel == 2'd0) begin m_xen = wdata[8]; m_een = wdata[9]; m_ben = wdata[10]; end
    m_sb   = p_sb   || (m_sb && !dwr);
    m_txe  = p_txe  || (m_txe && !dwr);
    m_rxne = p_rxne || (m_rxne && !drd);
    m_btf  = p_btf  || (m_btf && !(dwr || drd));
    m_berr = p_berr || (m_berr && !(awr && !wdata[8]));
    m_arlo = p_arlo || (m_arlo && !(awr && !wdata[9]));
    m_af   = p_nack || (m_af && !(awr && !wdata[10]));
    m_busy = p_bst  || (m_busy && !p_bsp);
    if (brd) begin
      m_addr = p_addr || (m_addr && !m_arm);
      m_arm = 1'b0;
    end else begin
      if (ard && m_addr) m_arm = 1'b1;
      m_addr = p_addr || m_addr;
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rd_reg(input logic [1:0] s);
    sel = s; rd = 1'b1; cycle();
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
    sel = s; wr = 1'b1; wdata = d; cycle();
  endtask

  initial begin
    int n = 0;
    while (n < 100000) begin @(posedge clk); n++; end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    tag = "R1";
    rd_reg(2'd0); rd_reg(2'd2); rd_reg(2'd3);

    // R12 control readback with stray bits
    tag = "R12";
    wr_reg(2'd0, 16'hFFFF); rd_reg(2'd0);
    wr_reg(2'd0, 16'h0200); rd_reg(2'd0);

    // R5 two-step address clear
    tag = "R5";
    p_addr = 1'b1; cycle();
    rd_reg(2'd3); rd_reg(2'd2);
    wr_reg(2'd1, 16'h0055);
    rd_reg(2'd3); rd_reg(2'd2);

    // R3 / R4 data-register side effects
    tag = "R3";
    p_sb = 1'b1; p_txe = 1'b1; p_btf = 1'b1; cycle();
    rd_reg(2'd2); wr_reg(2'd1, 16'h00A0); rd_reg(2'd2);
    tag = "R4";
    p_rxne = 1'b1; p_btf = 1'b1; cycle();
    rd_reg(2'd1); rd_reg(2'd2);

    // R9 buffer enable widens only with event enable
    tag = "R9";
    p_txe = 1'b1; cycle();
    wr_reg(2'd0, 16'h0400); wr_reg(2'd0, 16'h0200); wr_reg(2'd0, 16'h0600);
    wr_reg(2'd1, 16'h0000);

    // R6 write-zero clears, write-one keeps
    tag = "R6";
    wr_reg(2'd0, 16'h0100);
    p_nack = 1'b1; p_arlo = 1'b1; p_berr = 1'b1; p_sb = 1'b1; cycle();
    wr_reg(2'd2, 16'hFFFF); rd_reg(2'd2);
    wr_reg(2'd2, 16'hFBFF); rd_reg(2'd2);
    // R7 set pulse beats clear in the same cycle
    tag = "R7";
    p_nack = 1'b1; sel = 2'd2; wr = 1'b1; wdata = 16'h0000; cycle();
    rd_reg(2'd2);
    wr_reg(2'd2, 16'h0000); rd_reg(2'd2);

    // R11 busy
    tag = "R11";
    p_bst = 1'b1; cycle(); rd_reg(2'd3);
    p_bst = 1'b1; p_bsp = 1'b1; cycle(); rd_reg(2'd3);
    p_bsp = 1'b1; cycle(); rd_reg(2'd3);

    // random traffic
    tag = "rand";
    for (int k = 0; k < 4000; k++) begin
      p_sb   = ($urandom_range(0, 15) == 0);
      p_addr = ($urandom_range(0, 15) == 0);
      p_btf  = ($urandom_range(0, 15) == 0);
      p_txe  = ($urandom_range(0, 11) == 0);
      p_rxne = ($urandom_range(0, 11) == 0);
      p_nack = ($urandom_range(0, 23) == 0);
      p_arlo = ($urandom_range(0, 23) == 0);
      p_berr = ($urandom_range(0, 23) == 0);
      p_bst  = ($urandom_range(0, 19) == 0);
      p_bsp  = ($urandom_range(0, 19) == 0);
      sel    = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0: wr = 1'b1;
        1, 2: rd = 1'b1;
        default: ;
      endcase
      wdata = 16'($urandom);
      cycle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule